// File: doc/BRIEF.md
# Three-Tap Transmit De-Emphasis Filter

This block shapes a serial bit stream before it reaches a digital-to-analog line driver. Each symbol is turned into ±1. Three signed weights are applied across a window of three adjacent symbols: the upcoming symbol (pre-cursor), the current symbol (main cursor) and the previous symbol (post-cursor). The sum is a signed amplitude code. With negative side taps, the filter cuts low-frequency swing and keeps the transitions, which offsets the high-frequency loss of a long copper channel.

Coefficients are written as a complete set of three. A set whose absolute values add up to more than full scale is refused, and a one-cycle flag reports the refusal. An accepted set is staged, then applied to all three taps at once on a symbol boundary. A built-in test mode replaces the data with runs of eight zeros and eight ones, so the low-frequency amplitude left by the chosen de-emphasis can be measured. The usual tuning flow sets the main tap near full scale, fixes the pre-cursor and steps the post-cursor.

Top module: `tx_fir3`

## Requirements
- R1: On each clock edge with `sym_en` high, the incoming bit b[n] is mapped to x = +1 for 1 and -1 for 0. `dac_code` becomes pre·x[n] + main·x[n-1] + post·x[n-2]. The main cursor therefore lags the input by one symbol.
- R2: While `rst` is high (synchronous, active high), `dac_code` is 0 and `cfg_reject` is 0. After reset the active taps are pre = 0, main = +31, post = 0, and both history symbols are 0 (x = -1).
- R3: On an edge with `sym_en` low, `dac_code` and the symbol history keep their values.
- R4: A write (`cfg_wr` high) with |pre| + |main| + |post| > 31 is refused. Any tap at -32 is therefore refused. `cfg_reject` is 1 in exactly the cycle after a refused write and 0 otherwise. A refused write changes neither the active taps nor a set already staged.
- R5: An accepted write is staged. It becomes active at the first `sym_en` edge strictly after the write edge, and all three taps change together. The symbol computed at that commit edge still uses the previous set. A newer accepted write replaces a staged set that has not yet been committed.
- R6: While `pat_mode` is high, `din` is ignored. The symbols fed to the filter are 8 zeros then 8 ones, repeating, and advance only on `sym_en` edges. The pattern always starts at its first zero when `pat_mode` rises.
- R7: |`dac_code`| never exceeds 31.
- R8: When `pat_mode` falls, `din` feeds the filter again, and the history keeps the last pattern symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_en | input | 1 | Symbol boundary strobe |
| din | input | 1 | Serial data bit |
| pat_mode | input | 1 | Select the 8-zero/8-one test pattern |
| cfg_wr | input | 1 | Write strobe for a coefficient set |
| cfg_pre | input | 6 | Signed pre-cursor weight |
| cfg_main | input | 6 | Signed main-cursor weight |
| cfg_post | input | 6 | Signed post-cursor weight |
| cfg_reject | output | 1 | Pulses after a refused write |
| dac_code | output | 7 | Signed amplitude code |

## Verification
A corrupt history symbol shows up as an error of exactly twice one tap weight. It appears in the first symbol that uses it and lasts for up to two symbols. A wrong active coefficient set shows up as a wrong code on every symbol after the commit edge. A pattern counter that is off is visible within one 16-symbol period, where a run of the wrong length shifts the pre-cursor edge. The reference model follows these paths cycle by cycle. The bench drives sparse `sym_en`, tap writes on and off symbol edges, refused writes while a set is staged, and re-entry into pattern mode in the middle of a run.

// File: rtl/tx_fir3_pkg.sv
package tx_fir3_pkg;
    localparam int TAP_W   = 6;
    localparam int FULL    = (1 << (TAP_W - 1)) - 1;
    localparam int OUT_W   = TAP_W + 1;
    localparam int SUM_W   = TAP_W + 3;
    localparam int RUN_LEN = 8;

    typedef logic signed [TAP_W-1:0] coef_t;
    typedef logic signed [OUT_W-1:0] code_t;
    typedef logic signed [SUM_W-1:0] acc_t;

    typedef struct packed {
        coef_t pre;
        coef_t main;
        coef_t post;
    } tap_set_t;

    typedef enum logic { SRC_DATA = 1'b0, SRC_PATTERN = 1'b1 } src_sel_t;

    localparam tap_set_t RESET_TAPS = '{pre: '0, main: coef_t'(FULL), post: '0};

    function automatic acc_t mag(input coef_t c);
        acc_t w;
        w = acc_t'(c);
        return (w < 0) ? -w : w;
    endfunction

    function automatic logic set_ok(input tap_set_t s);
        return (mag(s.pre) + mag(s.main) + mag(s.post)) <= acc_t'(FULL);
    endfunction

    function automatic acc_t weigh(input coef_t c, input logic b);
        return b ? acc_t'(c) : -acc_t'(c);
    endfunction
endpackage

// File: rtl/tx_fir3_coef.sv
module tx_fir3_coef
    import tx_fir3_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sym_en,
    input  logic     wr,
    input  tap_set_t wr_set,
    output tap_set_t active,
    output logic     reject
);
    tap_set_t staged;
    logic     staged_vld;
    logic     ok;

    assign ok = set_ok(wr_set);

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= RESET_TAPS;
            staged     <= RESET_TAPS;
            staged_vld <= 1'b0;
            reject     <= 1'b0;
        end else begin
            reject <= wr && !ok;
            if (sym_en && staged_vld) begin
                active <= staged;
            end
            if (wr && ok) begin
                staged     <= wr_set;
                staged_vld <= 1'b1;
            end else if (sym_en) begin
                staged_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_fir3_src.sv
module tx_fir3_src
    import tx_fir3_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_en,
    input  logic       pat_mode,
    input  logic       din,
    output logic       bit_now,
    output logic [1:0] hist
);
    localparam int PERIOD = 2 * RUN;
    localparam int CNT_W  = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt;
    logic             pat_bit;
    src_sel_t         sel;

    assign sel     = pat_mode ? SRC_PATTERN : SRC_DATA;
    assign pat_bit = (int'(cnt) >= RUN);

    always_comb begin
        unique case (sel)
            SRC_PATTERN: bit_now = pat_bit;
            default:     bit_now = din;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            hist <= '0;
        end else begin
            if (sel == SRC_DATA) begin
                cnt <= '0;
            end else if (sym_en) begin
                cnt <= (int'(cnt) == PERIOD - 1) ? '0 : cnt + 1'b1;
            end
            if (sym_en) begin
                hist <= {hist[0], bit_now};
            end
        end
    end
endmodule

// File: rtl/tx_fir3_sum.sv
module tx_fir3_sum
    import tx_fir3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sym_en,
    input  tap_set_t   taps,
    input  logic       bit_now,
    input  logic [1:0] hist,
    output code_t      code
);
    acc_t total;

    always_comb begin
        total = weigh(taps.pre, bit_now)
              + weigh(taps.main, hist[0])
              + weigh(taps.post, hist[1]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (sym_en) begin
            code <= code_t'(total);
        end
    end
endmodule

// File: rtl/tx_fir3.sv
module tx_fir3
    import tx_fir3_pkg::*;
#(
    parameter int RUN = RUN_LEN
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sym_en,
    input  logic                     din,
    input  logic                     pat_mode,
    input  logic                     cfg_wr,
    input  logic signed [TAP_W-1:0]  cfg_pre,
    input  logic signed [TAP_W-1:0]  cfg_main,
    input  logic signed [TAP_W-1:0]  cfg_post,
    output logic                     cfg_reject,
    output logic signed [OUT_W-1:0]  dac_code
);
    tap_set_t   wr_set;
    tap_set_t   active;
    logic       bit_now;
    logic [1:0] hist;

    assign wr_set = '{pre: cfg_pre, main: cfg_main, post: cfg_post};

    tx_fir3_coef u_coef (
        .clk    (clk),
        .rst    (rst),
        .sym_en (sym_en),
        .wr     (cfg_wr),
        .wr_set (wr_set),
        .active (active),
        .reject (cfg_reject)
    );

    tx_fir3_src #(.RUN(RUN)) u_src (
        .clk      (clk),
        .rst      (rst),
        .sym_en   (sym_en),
        .pat_mode (pat_mode),
        .din      (din),
        .bit_now  (bit_now),
        .hist     (hist)
    );

    tx_fir3_sum u_sum (
        .clk     (clk),
        .rst     (rst),
        .sym_en  (sym_en),
        .taps    (active),
        .bit_now (bit_now),
        .hist    (hist),
        .code    (dac_code)
    );
endmodule

// File: rtl/tx_fir3_chk.sv
module tx_fir3_chk
    import tx_fir3_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    sym_en,
    input logic                    cfg_wr,
    input logic signed [TAP_W-1:0] cfg_pre,
    input logic signed [TAP_W-1:0] cfg_main,
    input logic signed [TAP_W-1:0] cfg_post,
    input logic                    cfg_reject,
    input logic signed [OUT_W-1:0] dac_code
);
    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    logic too_big;
    assign too_big = (absi(int'(cfg_pre)) + absi(int'(cfg_main)) + absi(int'(cfg_post))) > FULL;

    p_range_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(dac_code) <= FULL) && (int'(dac_code) >= -FULL));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !sym_en |=> $stable(dac_code));

    p_refuse_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && too_big) |=> cfg_reject);

    p_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && too_big) |=> !cfg_reject);

    p_reset_r2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_code == '0) && !cfg_reject);
endmodule

bind tx_fir3 tx_fir3_chk u_chk (.*);

// File: tb/sim_tx_fir3.sv
module sim_tx_fir3;
    localparam int CLK_PERIOD = 10;
    localparam int RUN = 8;
    localparam int FS = 31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_en = 1'b0, din = 1'b0, pat_mode = 1'b0, cfg_wr = 1'b0;
    logic signed [5:0] cfg_pre = '0, cfg_main = '0, cfg_post = '0;
    logic cfg_reject;
    logic signed [6:0] dac_code;

    int checks = 0, errors = 0;
    string cur_req = "R2";
    bit finished = 0;

    // behavioural reference state
    int m_out = 0, m_rej = 0;
    int a_pre = 0, a_main = FS, a_post = 0;
    int p_pre = 0, p_main = FS, p_post = 0;
    bit pend = 0;
    int h[$];
    int pc = 0;
    int lfsr = 32'h1234_5678;

    tx_fir3 u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sg(input int b);
        return b ? 1 : -1;
    endfunction

    function automatic int absi(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic bit legal(input int p, input int m, input int q);
        return (absi(p) + absi(m) + absi(q)) <= FS;
    endfunction

    initial begin
        h.push_back(0);
        h.push_back(0);
    end

    always @(posedge clk) begin
        int b;
        bit ok;
        if (rst) begin
            m_out = 0; m_rej = 0;
            a_pre = 0; a_main = FS; a_post = 0;
            pend = 0; pc = 0;
            h = '{0, 0};
        end else begin
            ok = legal(int'(cfg_pre), int'(cfg_main), int'(cfg_post));
            m_rej = (cfg_wr && !ok) ? 1 : 0;
            if (sym_en) begin
                b = pat_mode ? ((pc >= RUN) ? 1 : 0) : int'(din);
                m_out = a_pre * sg(b) + a_main * sg(h[0]) + a_post * sg(h[1]);
                h = '{b, h[0]};
                if (pend) begin
                    a_pre = p_pre; a_main = p_main; a_post = p_post;
                end
            end
            if (!pat_mode) pc = 0;
            else if (sym_en) pc = (pc + 1) % (2 * RUN);
            if (cfg_wr && ok) begin
                p_pre = int'(cfg_pre); p_main = int'(cfg_main); p_post = int'(cfg_post);
                pend = 1;
            end else if (sym_en) begin
                pend = 0;
            end
        end
    end

    task automatic compare();
        int got;
        got = int'(dac_code);
        checks++;
        if (got != m_out) begin
            errors++;
            $display("FAIL %s dac_code actual %0d expected %0d at %0t", cur_req, got, m_out, $time);
        end
        checks++;
        if (int'(cfg_reject) != m_rej) begin
            errors++;
            $display("FAIL %s cfg_reject actual %0d expected %0d at %0t", cur_req, cfg_reject, m_rej, $time);
        end
        checks++;
        if (absi(got) > FS) begin
            errors++;
            $display("FAIL R7 |dac_code| actual %0d expected <= %0d", got, FS);
        end
    endtask

    function automatic int rnd();
        lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
        return lfsr;
    endfunction

    task automatic step(input bit se, input bit d, input bit pm,
                        input bit wr, input int p, input int m, input int q);
        @(negedge clk);
        compare();
        sym_en = se; din = d; pat_mode = pm; cfg_wr = wr;
        cfg_pre = p[5:0]; cfg_main = m[5:0]; cfg_post = q[5:0];
    endtask

    task automatic data(input int n, input bit sparse);
        for (int i = 0; i < n; i++) begin
            int r;
            r = rnd();
            step(sparse ? r[3] : 1'b1, r[0], 1'b0, 1'b0, 0, 0, 0);
        end
    endtask

    initial begin
        // R2: reset state
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (dac_code !== '0 || cfg_reject !== 1'b0) begin
                errors++;
                $display("FAIL R2 reset outputs actual %0d/%0b expected 0/0", dac_code, cfg_reject);
            end
        end
        rst = 1'b0;
        // R2: reset taps (main 31, history -1), din=1 gives -31 then +31
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        // R1: full-scale legal set, random data
        cur_req = "R1";
        step(0, 0, 0, 1, -4, 20, -7);
        step(1, 0, 0, 0, 0, 0, 0);
        data(40, 0);

        // R3: sparse symbol strobe
        cur_req = "R3";
        data(40, 1);

        // R4: refused writes, including one while a legal set is staged
        cur_req = "R4";
        step(0, 0, 0, 1, -32, 0, 0);
        step(0, 0, 0, 1, 10, 20, 2);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 1, -2, 25, -4);
        step(0, 0, 0, 1, 0, 31, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        data(12, 0);

        // R5: staged write held over idle cycles, write on a symbol edge, overwrite
        cur_req = "R5";
        step(0, 0, 0, 1, 3, 22, -6);
        repeat (5) step(0, 1, 0, 0, 0, 0, 0);
        data(6, 0);
        step(1, 1, 0, 1, -1, 30, 0);
        data(5, 0);
        step(0, 0, 0, 1, -5, 10, -5);
        step(0, 0, 0, 1, 0, 16, -15);
        data(8, 0);
        // post-cursor sweep with fixed pre-cursor and main at its ceiling
        for (int k = 0; k <= 8; k++) begin
            step(0, 0, 0, 1, -3, FS - 3 - k, -k);
            data(6, 0);
        end

        // R6: pattern mode, din toggling, gaps, re-entry mid-run
        cur_req = "R6";
        step(0, 0, 0, 1, -3, 20, -8);
        for (int i = 0; i < 40; i++) step(1, i[0], 1, 0, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(i[1], ~i[0], 1, 0, 0, 0, 0);
        step(1, 1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 36; i++) step(1, 1, 1, 0, 0, 0, 0);

        // R8: back to data, history continuous
        cur_req = "R8";
        data(20, 0);
        data(10, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule